// File: doc/BRIEF.md
# Relative Clock Frequency Monitor

This block measures how fast one of several candidate clocks runs compared with a fixed reference clock. Software picks a candidate, writes a window length in reference cycles and sets a start bit. A down-counter in the reference domain opens a window of that many reference cycles. During the window an up-counter clocked by the chosen candidate counts its edges. The run ends when the window closes or when the edge counter reaches its ceiling, whichever comes first. The start bit then drops back to 0 on its own.

Once the start bit reads 0, software reads the edge count and the leftover reference count. The candidate frequency is the edge count divided by (programmed window minus leftover), times the reference frequency. If the window is set to the reference frequency in kHz and the run ends on the window, the edge count gives the candidate frequency in kHz directly.

The three clock domains (register, reference, measured) exchange start, run, acknowledge, saturation and done events through two-flop synchronizers with a handshake. The results are captured into register-domain flops only after the measured domain has stopped, so every readback is stable.

Top module: `fmon_top`

## Requirements
- R1: After reset, `stat_busy` is 0 and both `stat_meas_count` and `stat_ref_count` are 0.
- R2: A write with `cfg_start`=1 and a nonzero `cfg_ref_count` while idle makes `stat_busy` read 1 at the next `clk` edge.
- R3: When the run ends on the window and N = `cfg_ref_count`, the edge count lies between N*f_sel/f_ref - 1 and N*f_sel/f_ref + 6*f_sel/f_ref + 6. This also holds for a candidate that runs faster than the reference.
- R4: The R3 bound also holds for a candidate that runs slower than the reference.
- R5: When the run ends on the window, `stat_ref_count` reads 0. While the window is open, the reference counter drops by exactly one on each reference cycle.
- R6: If the edge count reaches 2^14-1 before the window closes, the count stops there without wrapping and the run ends. The leftover reference count is then nonzero and matches the edges counted.
- R7: `stat_busy` returns to 0 by itself within N+40 reference cycles of the start write.
- R8: A start write while `stat_busy` is 1 is ignored. The running measurement keeps the clock select and window it started with.
- R9: A start write with `cfg_ref_count`=0 completes at once. At the next `clk` edge `stat_busy` is 0 and both counts read 0.
- R10: While `stat_busy` is 1, `stat_meas_count` and `stat_ref_count` keep the results of the previous run.
- R11: A write with `cfg_start`=0 starts nothing and leaves the results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-domain clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of the slowest clock |
| ref_clk | input | 1 | Fixed-frequency reference clock |
| meas_clks | input | NUM_CLK | Candidate clocks, index chosen by `cfg_sel` |
| cfg_wr | input | 1 | Register write strobe |
| cfg_start | input | 1 | Start bit value carried by the write |
| cfg_sel | input | SEL_W | Candidate clock index |
| cfg_ref_count | input | RCNT_W | Window length in reference cycles |
| stat_busy | output | 1 | Start bit readback, 1 while a run is in progress |
| stat_meas_count | output | MCNT_W | Edges counted in the last run |
| stat_ref_count | output | RCNT_W | Reference count left at the end of the last run |

## Verification
`stat_busy` rises one `clk` edge after an accepted start write. A zero window instead clears both counts at that same edge. The bench drives writes on the falling edge and samples one falling edge later. Completion passes through synchronizers in three domains, so its exact cycle is not fixed. For each run the bench therefore polls `stat_busy` on falling edges against a limit of N+40 reference cycles, and reads the counts only after it drops. The bench does not expect one exact edge count. It checks the count against a window derived from the clock periods, which covers the synchronizer latency at both ends of the measurement window.

// File: rtl/fmon_pkg.sv
package fmon_pkg;
  typedef enum logic [1:0] {
    REF_IDLE,
    REF_ARM,
    REF_COUNT,
    REF_DRAIN
  } ref_state_t;
endpackage

// File: rtl/fmon_sync.sv
module fmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/fmon_meas_ctr.sv
module fmon_meas_ctr #(
  parameter int W    = 14,
  parameter int SYNC = 2
) (
  input  logic         meas_clk,
  input  logic         rst,
  input  logic         run_i,
  output logic         ack_o,
  output logic         sat_o,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] CNT_MAX  = {W{1'b1}};
  localparam logic [W-1:0] CNT_LAST = CNT_MAX - 1'b1;

  logic run_s, run_q, clr, step;

  fmon_sync #(.STAGES(SYNC)) u_run_sync (
    .clk(meas_clk), .rst(rst), .d(run_i), .q(run_s)
  );

  assign clr  = run_s & ~run_q;
  assign step = run_s & run_q & ~sat_o;

  always_ff @(posedge meas_clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      count_o <= '0;
      sat_o   <= 1'b0;
    end else begin
      run_q <= run_s;
      if (clr) begin
        count_o <= '0;
        sat_o   <= 1'b0;
      end else if (step) begin
        count_o <= count_o + 1'b1;
        if (count_o == CNT_LAST) sat_o <= 1'b1;
      end
    end
  end

  assign ack_o = run_q;

  // R6: the edge counter holds at its ceiling while the run level stays high
  p_no_wrap_r6: assert property (@(posedge meas_clk) disable iff (rst)
    (count_o == CNT_MAX) && run_s && run_q |=> count_o == CNT_MAX);

  // R10: once the run level is gone the count is frozen for readback
  p_frozen_idle_r10: assert property (@(posedge meas_clk) disable iff (rst)
    !run_s && !run_q |=> $stable(count_o));
endmodule

// File: rtl/fmon_ref_ctr.sv
module fmon_ref_ctr
  import fmon_pkg::*;
#(
  parameter int W    = 9,
  parameter int SYNC = 2
) (
  input  logic         ref_clk,
  input  logic         rst,
  input  logic         start_tgl_i,
  input  logic [W-1:0] load_i,
  input  logic         ack_i,
  input  logic         sat_i,
  output logic         run_o,
  output logic         done_tgl_o,
  output logic [W-1:0] count_o
);
  ref_state_t st;
  logic start_s, start_q, ack_s, sat_s;

  fmon_sync #(.STAGES(SYNC)) u_start_sync (
    .clk(ref_clk), .rst(rst), .d(start_tgl_i), .q(start_s)
  );
  fmon_sync #(.STAGES(SYNC)) u_ack_sync (
    .clk(ref_clk), .rst(rst), .d(ack_i), .q(ack_s)
  );
  fmon_sync #(.STAGES(SYNC)) u_sat_sync (
    .clk(ref_clk), .rst(rst), .d(sat_i), .q(sat_s)
  );

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      st         <= REF_IDLE;
      start_q    <= 1'b0;
      run_o      <= 1'b0;
      done_tgl_o <= 1'b0;
      count_o    <= '0;
    end else begin
      start_q <= start_s;
      case (st)
        REF_IDLE: begin
          if (start_s != start_q) begin
            count_o <= load_i;
            run_o   <= 1'b1;
            st      <= REF_ARM;
          end
        end
        REF_ARM: begin
          if (ack_s) st <= REF_COUNT;
        end
        REF_COUNT: begin
          if (count_o == '0 || sat_s) begin
            run_o <= 1'b0;
            st    <= REF_DRAIN;
          end else begin
            count_o <= count_o - 1'b1;
          end
        end
        REF_DRAIN: begin
          if (!ack_s) begin
            done_tgl_o <= ~done_tgl_o;
            st         <= REF_IDLE;
          end
        end
        default: st <= REF_IDLE;
      endcase
    end
  end

  // R5: one decrement per reference cycle while the window is open
  p_ref_step_r5: assert property (@(posedge ref_clk) disable iff (rst)
    (st == REF_COUNT) && (count_o != '0) && !sat_s |=> count_o == $past(count_o) - 1'b1);

  // R7: the run level is released before completion is reported
  p_drain_low_r7: assert property (@(posedge ref_clk) disable iff (rst)
    (st == REF_DRAIN) |-> !run_o);

  // R5: a window that reached zero leaves the reference count at zero
  p_zero_kept_r5: assert property (@(posedge ref_clk) disable iff (rst)
    (st == REF_COUNT) && (count_o == '0) |=> count_o == '0);
endmodule

// File: rtl/fmon_top.sv
module fmon_top #(
  parameter int NUM_CLK = 4,
  parameter int MCNT_W  = 14,
  parameter int RCNT_W  = 9,
  parameter int SYNC    = 2,
  localparam int SEL_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_clk,
  input  logic [NUM_CLK-1:0] meas_clks,
  input  logic               cfg_wr,
  input  logic               cfg_start,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [RCNT_W-1:0]  cfg_ref_count,
  output logic               stat_busy,
  output logic [MCNT_W-1:0]  stat_meas_count,
  output logic [RCNT_W-1:0]  stat_ref_count
);
  logic [SEL_W-1:0]  sel_q;
  logic [RCNT_W-1:0] window_q;
  logic              start_tgl, done_tgl, done_s, done_q;
  logic              meas_clk, run, ack, sat;
  logic [MCNT_W-1:0] meas_cnt;
  logic [RCNT_W-1:0] ref_cnt;
  logic              accept, finish;

  generate
    if (NUM_CLK == (1 << SEL_W)) begin : g_mux_full
      assign meas_clk = meas_clks[sel_q];
    end else begin : g_mux_part
      assign meas_clk = (int'(sel_q) < NUM_CLK) ? meas_clks[sel_q] : 1'b0;
    end
  endgenerate

  fmon_meas_ctr #(.W(MCNT_W), .SYNC(SYNC)) u_meas (
    .meas_clk(meas_clk), .rst(rst), .run_i(run),
    .ack_o(ack), .sat_o(sat), .count_o(meas_cnt)
  );

  fmon_ref_ctr #(.W(RCNT_W), .SYNC(SYNC)) u_ref (
    .ref_clk(ref_clk), .rst(rst), .start_tgl_i(start_tgl), .load_i(window_q),
    .ack_i(ack), .sat_i(sat), .run_o(run), .done_tgl_o(done_tgl), .count_o(ref_cnt)
  );

  fmon_sync #(.STAGES(SYNC)) u_done_sync (
    .clk(clk), .rst(rst), .d(done_tgl), .q(done_s)
  );

  assign accept = cfg_wr && cfg_start && !stat_busy;
  assign finish = stat_busy && (done_s != done_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_busy       <= 1'b0;
      sel_q           <= '0;
      window_q        <= '0;
      start_tgl       <= 1'b0;
      done_q          <= 1'b0;
      stat_meas_count <= '0;
      stat_ref_count  <= '0;
    end else begin
      done_q <= done_s;
      if (accept) begin
        sel_q    <= cfg_sel;
        window_q <= cfg_ref_count;
        if (cfg_ref_count == '0) begin
          stat_meas_count <= '0;
          stat_ref_count  <= '0;
        end else begin
          stat_busy <= 1'b1;
          start_tgl <= ~start_tgl;
        end
      end else if (finish) begin
        stat_busy       <= 1'b0;
        stat_meas_count <= meas_cnt;
        stat_ref_count  <= ref_cnt;
      end
    end
  end

  // R2: an accepted nonzero start raises busy on the next edge
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && cfg_start && !stat_busy && (cfg_ref_count != '0) |=> stat_busy);

  // R9: a zero window never raises busy and reports zero counts
  p_zero_window_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && cfg_start && !stat_busy && (cfg_ref_count == '0)
      |=> !stat_busy && (stat_meas_count == '0) && (stat_ref_count == '0));

  // R10: results stay put during a run
  p_hold_results_r10: assert property (@(posedge clk) disable iff (rst)
    $past(stat_busy) && stat_busy |-> $stable(stat_meas_count) && $stable(stat_ref_count));

  // R8: configuration cannot change while a run is in progress
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    stat_busy |=> $stable(sel_q) && $stable(window_q));
endmodule

// File: tb/fmon_top_test.sv
`timescale 1ns/100ps
module fmon_top_test;
  localparam int NUM_CLK = 4;
  localparam int MCNT_W  = 14;
  localparam int RCNT_W  = 9;
  localparam int SEL_W   = 2;
  localparam int MAXC    = (1 << MCNT_W) - 1;
  localparam int PREF    = 40;
  localparam int PM0 = 10, PM1 = 1, PM2 = 40, PM3 = 160;

  logic clk = 0, ref_clk = 0, c0 = 0, c1 = 0, c2 = 0, c3 = 0;
  logic rst = 1;
  logic cfg_wr = 0, cfg_start = 0;
  logic [SEL_W-1:0] cfg_sel = '0;
  logic [RCNT_W-1:0] cfg_ref_count = '0;
  logic stat_busy;
  logic [MCNT_W-1:0] stat_meas_count;
  logic [RCNT_W-1:0] stat_ref_count;
  logic [NUM_CLK-1:0] meas_clks;

  int total = 0, fails = 0;

  always #10    clk = ~clk;
  always #20    ref_clk = ~ref_clk;
  always #5     c0 = ~c0;
  always #0.5   c1 = ~c1;
  always #20    c2 = ~c2;
  always #80    c3 = ~c3;
  assign meas_clks = {c3, c2, c1, c0};

  fmon_top #(.NUM_CLK(NUM_CLK), .MCNT_W(MCNT_W), .RCNT_W(RCNT_W)) uut (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .meas_clks(meas_clks),
    .cfg_wr(cfg_wr), .cfg_start(cfg_start), .cfg_sel(cfg_sel),
    .cfg_ref_count(cfg_ref_count), .stat_busy(stat_busy),
    .stat_meas_count(stat_meas_count), .stat_ref_count(stat_ref_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input int sel);
    case (sel)
      0: return PM0;
      1: return PM1;
      2: return PM2;
      default: return PM3;
    endcase
  endfunction

  task automatic write(input bit start, input int sel, input int n);
    @(negedge clk);
    cfg_wr = 1; cfg_start = start; cfg_sel = SEL_W'(sel); cfg_ref_count = RCNT_W'(n);
    @(negedge clk);
    cfg_wr = 0; cfg_start = 0;
  endtask

  task automatic wait_done(input int n, input string req);
    int lim = (n + 40) * 2;
    int cyc = 0;
    while (stat_busy && cyc < lim) begin
      @(negedge clk);
      cyc++;
    end
    chk(!stat_busy, req, cyc, lim);
  endtask

  task automatic check_window(input int sel, input int n, input string req);
    int pm = period_of(sel);
    int ideal = n * PREF / pm;
    int lo = ideal - 1;
    int hi = ideal + (6 * PREF) / pm + 6;
    chk(int'(stat_meas_count) >= lo && int'(stat_meas_count) <= hi, req,
        int'(stat_meas_count), ideal);
    chk(stat_ref_count == 0, "R5 leftover zero", int'(stat_ref_count), 0);
  endtask

  task automatic t_reset();
    chk(stat_busy == 0, "R1 busy", int'(stat_busy), 0);
    chk(stat_meas_count == 0, "R1 meas", int'(stat_meas_count), 0);
    chk(stat_ref_count == 0, "R1 ref", int'(stat_ref_count), 0);
  endtask

  task automatic t_run(input int sel, input int n, input string req);
    int pm, pr;
    pm = int'(stat_meas_count);
    pr = int'(stat_ref_count);
    write(1, sel, n);
    chk(stat_busy == 1, "R2 busy after start", int'(stat_busy), 1);
    repeat (20) @(negedge clk);
    chk(int'(stat_meas_count) == pm, "R10 meas held", int'(stat_meas_count), pm);
    chk(int'(stat_ref_count) == pr, "R10 ref held", int'(stat_ref_count), pr);
    wait_done(n, "R7 busy clears");
    check_window(sel, n, req);
  endtask

  task automatic t_saturate();
    int left, w, err;
    write(1, 1, 511);
    wait_done(511, "R7 busy clears sat");
    chk(stat_meas_count == MCNT_W'(MAXC), "R6 count at ceiling", int'(stat_meas_count), MAXC);
    left = int'(stat_ref_count);
    chk(left > 0, "R6 leftover nonzero", left, 1);
    w = 511 - left;
    err = w * (PREF / PM1) - MAXC;
    chk(err >= -8 * (PREF / PM1) && err <= 4 * (PREF / PM1), "R6 leftover matches",
        w * (PREF / PM1), MAXC);
  endtask

  task automatic t_ignore();
    write(1, 0, 100);
    repeat (4) @(negedge clk);
    write(1, 3, 5);
    chk(stat_busy == 1, "R8 still busy", int'(stat_busy), 1);
    wait_done(100, "R7 busy clears ign");
    check_window(0, 100, "R8 original config kept");
  endtask

  task automatic t_zero();
    write(1, 2, 0);
    chk(stat_busy == 0, "R9 not busy", int'(stat_busy), 0);
    chk(stat_meas_count == 0, "R9 meas zero", int'(stat_meas_count), 0);
    chk(stat_ref_count == 0, "R9 ref zero", int'(stat_ref_count), 0);
  endtask

  task automatic t_nostart();
    int pm = int'(stat_meas_count);
    write(0, 1, 50);
    repeat (6) @(negedge clk);
    chk(stat_busy == 0, "R11 no run", int'(stat_busy), 0);
    chk(int'(stat_meas_count) == pm, "R11 result kept", int'(stat_meas_count), pm);
  endtask

  initial begin
    #8_000_000;
    fails++; total++;
    $display("FAIL R7 watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_run(0, 100, "R3 fast clock");
    t_nostart();
    t_run(2, 64, "R3 equal clock");
    t_run(3, 200, "R4 slow clock");
    t_zero();
    t_run(0, 37, "R3 short window");
    t_saturate();
    t_ignore();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule